// File: doc/BRIEF.md
# Two-Way Write-Back Line Cache

This block sits between a 32-bit processor bus and a wide external-memory port. It holds 128 KB of data in two ways of 256 sets. Each line is 256 bytes. A word read or a byte-enabled write that hits is served from on-chip storage in the same cycle it is requested. A miss picks the least recently used way of the set. If that line is dirty, it is first streamed out to memory. The wanted line is then fetched in 128-bit beats, and the stalled access is replayed against the fresh line.

The cache does not start empty. Its tag store comes out of reset already describing the lowest 128 KB of the address space, so a processor can run from that region at once, with no fetch. Way 0 covers the first 64 KB and way 1 the second 64 KB. All preset lines are valid and clean. A single four-state controller sequences lookup, write-back, refill and replay.

Top module: `twoway_wb_cache`

## Requirements
- R1: Coming out of reset, with no request, cpu_ready and mem_req are low. Any access to a byte address below 131072 completes as a hit without memory traffic.
- R2: A byte address splits into offset [7:0], set index [15:8] and tag [22:16]. Bits [3:2] choose the 32-bit lane of a 128-bit beat. A read hit drives the addressed word on cpu_rdata, and cpu_ready is high in the same cycle the request is first presented.
- R3: A write hit replaces only the byte lanes whose cpu_be bit is set (bit i covers bits 8i+7:8i), marks the line dirty and causes no memory traffic.
- R4: On a miss, cpu_ready stays low from the lookup cycle until the replayed access completes. A write miss allocates the line and then merges the write.
- R5: A dirty victim is written back before any refill request. The write-back is 16 write beats with mem_we high and mem_addr equal to the victim's {tag,index} (its byte address shifted right by 8). Beat k carries line bytes 16k to 16k+15.
- R6: A clean victim produces no write beats; the miss goes straight to one read request.
- R7: A refill issues one read request with mem_we low and mem_addr equal to the missing line's {tag,index}. It then accepts 16 mem_rvalid beats, beat k being stored as line bytes 16k to 16k+15. The requested word is returned by the replay.
- R8: Each set keeps one LRU bit. A hit or a fill makes the other way least recently used, and the victim of a miss is the least recently used way. After reset, way 0 is least recently used in every set.
- R9: Once raised, mem_req stays high with mem_we, mem_addr and mem_wdata unchanged until a cycle in which mem_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 23 | Word-aligned byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory request (write beat or line read) |
| mem_we | output | 1 | 1 = write-back beat, 0 = line read request |
| mem_addr | output | 15 | Line address {tag,index} |
| mem_wdata | output | 128 | Write-back beat data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Refill beat present |
| mem_rdata | input | 128 | Refill beat data |

## Verification
The assertions assume the processor side behaves: a request keeps its address, direction, data and byte enables until cpu_ready, and addresses are word aligned. They also assume memory returns refill beats only after a read request has been accepted. The bench drives each access from a single task that holds every request field constant until it sees cpu_ready. It uses only aligned addresses. Its memory model sends read beats only for a request it has recorded. Its stall patterns for mem_ready and mem_rvalid exercise held requests without breaking these premises.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int unsigned CPU_W          = 32;
  localparam int unsigned DEF_ADDR_W     = 23;
  localparam int unsigned DEF_SETS       = 256;
  localparam int unsigned DEF_LINE_BYTES = 256;
  localparam int unsigned DEF_MEM_W      = 128;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2,
    ST_REPLAY = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tags.sv
module wbc_tags #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned TAG_W  = 7,
  parameter bit          PRESET = 1'b1,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             sel_way,
  input  logic             touch,
  input  logic             touch_way,
  input  logic             mark_dirty,
  input  logic             fill,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             lru_way,
  output logic [TAG_W-1:0] sel_tag,
  output logic             sel_dirty
);
  logic [1:0]             way_hit;
  logic [1:0]             way_dirty;
  logic [1:0][TAG_W-1:0]  way_tag;
  logic [SETS-1:0]        lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) tag_q[s] <= TAG_W'(w);
        vld_q <= PRESET ? '1 : '0;
        drt_q <= '0;
      end else if (fill && fill_way == 1'(w)) begin
        tag_q[lk_idx] <= fill_tag;
        vld_q[lk_idx] <= 1'b1;
        drt_q[lk_idx] <= 1'b0;
      end else if (mark_dirty && touch_way == 1'(w)) begin
        drt_q[lk_idx] <= 1'b1;
      end
    end

    assign way_hit[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign way_tag[w]   = tag_q[lk_idx];
    assign way_dirty[w] = vld_q[lk_idx] && drt_q[lk_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lru_q <= '0;
    else if (touch) lru_q[lk_idx] <= ~touch_way;
  end

  assign hit       = |way_hit;
  assign hit_way   = way_hit[1];
  assign lru_way   = lru_q[lk_idx];
  assign sel_tag   = way_tag[sel_way];
  assign sel_dirty = way_dirty[sel_way];

  // R8: a used way is never the least recently used one afterwards
  a_r8_lru_flips: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> lru_q[$past(lk_idx)] != $past(touch_way))
    else $error("a_r8_lru_flips");

  // R2: one address can never match both ways
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit))
    else $error("a_r2_single_match");
endmodule

// File: rtl/wbc_data.sv
module wbc_data #(
  parameter int unsigned SETS  = 256,
  parameter int unsigned BEATS = 16,
  parameter int unsigned MEM_W = 128,
  localparam int unsigned RAM_AW = $clog2(SETS) + $clog2(BEATS),
  localparam int unsigned DEPTH  = SETS * BEATS,
  localparam int unsigned MASK_W = MEM_W / 8
) (
  input  logic                  clk,
  input  logic [RAM_AW-1:0]     rd_addr,
  input  logic                  wr_en,
  input  logic                  wr_way,
  input  logic [RAM_AW-1:0]     wr_addr,
  input  logic [MEM_W-1:0]      wr_data,
  input  logic [MASK_W-1:0]     wr_mask,
  output logic [1:0][MEM_W-1:0] rd_line
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [MEM_W-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 1'(w)) begin
        for (int b = 0; b < MASK_W; b++)
          if (wr_mask[b]) ram[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end

    assign rd_line[w] = ram[rd_addr];
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl import wbc_pkg::*; #(
  parameter int unsigned BEATS = 16,
  localparam int unsigned BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              hit,
  input  logic              hit_way,
  input  logic              lru_way,
  input  logic              sel_dirty,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  output wbc_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              way_q,
  output logic              access_go,
  output logic              miss_start,
  output logic              mem_req,
  output logic              mem_we,
  output logic              fill_beat,
  output logic              fill_last
);
  wbc_state_e        state_q;
  logic [BEAT_W-1:0] beat_q;
  logic              rd_sent_q;
  logic              victim_q;
  logic              last_beat;

  assign state = state_q;
  assign beat  = beat_q;
  assign way_q = victim_q;

  always_comb begin
    last_beat  = (beat_q == BEAT_W'(BEATS - 1));
    miss_start = (state_q == ST_LOOKUP) && cpu_req && !hit;
    access_go  = cpu_req && (((state_q == ST_LOOKUP) && hit) || (state_q == ST_REPLAY));
    mem_we     = (state_q == ST_WBACK);
    mem_req    = (state_q == ST_WBACK) || ((state_q == ST_REFILL) && !rd_sent_q);
    fill_beat  = (state_q == ST_REFILL) && rd_sent_q && mem_rvalid;
    fill_last  = fill_beat && last_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOOKUP;
      beat_q    <= '0;
      rd_sent_q <= 1'b0;
      victim_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOOKUP: if (miss_start) begin
          victim_q  <= lru_way;
          beat_q    <= '0;
          rd_sent_q <= 1'b0;
          state_q   <= sel_dirty ? ST_WBACK : ST_REFILL;
        end
        ST_WBACK: if (mem_ready) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_REFILL;
        end
        ST_REFILL: begin
          if (!rd_sent_q && mem_ready) rd_sent_q <= 1'b1;
          if (fill_beat) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_REPLAY;
          end
        end
        ST_REPLAY: state_q <= ST_LOOKUP;
        default:   state_q <= ST_LOOKUP;
      endcase
    end
  end

  // R4: the replayed access finds the freshly filled way
  a_r4_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REPLAY) |-> (hit && hit_way == victim_q))
    else $error("a_r4_replay_hits");

  // R4: the processor keeps its request up while stalled
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_LOOKUP) |-> cpu_req)
    else $error("a_r4_req_held");

  // R5: a dirty victim goes to write-back first
  a_r5_dirty_to_wback: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && sel_dirty) |=> (state_q == ST_WBACK))
    else $error("a_r5_dirty_to_wback");

  // R5: write-back is only ever followed by refill
  a_r5_wback_then_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK) |=> (state_q == ST_WBACK || state_q == ST_REFILL))
    else $error("a_r5_wback_then_refill");

  // R6: a clean victim skips write-back
  a_r6_clean_to_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !sel_dirty) |=> (state_q == ST_REFILL))
    else $error("a_r6_clean_to_refill");

  // R7: refill beats only come after the read request was taken
  a_r7_beats_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (state_q == ST_REFILL && rd_sent_q))
    else $error("a_r7_beats_after_request");
endmodule

// File: rtl/twoway_wb_cache.sv
module twoway_wb_cache import wbc_pkg::*; #(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned SETS       = DEF_SETS,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned MEM_W      = DEF_MEM_W,
  parameter bit          PRESET     = 1'b1,
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W   = $clog2(SETS),
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned LINE_AW = TAG_W + IDX_W,
  localparam int unsigned BE_W    = CPU_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [CPU_W-1:0]   cpu_wdata,
  input  logic [BE_W-1:0]    cpu_be,
  output logic               cpu_ready,
  output logic [CPU_W-1:0]   cpu_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LINE_AW-1:0] mem_addr,
  output logic [MEM_W-1:0]   mem_wdata,
  input  logic               mem_ready,
  input  logic               mem_rvalid,
  input  logic [MEM_W-1:0]   mem_rdata
);
  localparam int unsigned BEATS      = LINE_BYTES * 8 / MEM_W;
  localparam int unsigned BEAT_W     = $clog2(BEATS);
  localparam int unsigned BEAT_BYTES = MEM_W / 8;
  localparam int unsigned BB_W       = $clog2(BEAT_BYTES);
  localparam int unsigned LANES      = MEM_W / CPU_W;
  localparam int unsigned LANE_W     = $clog2(LANES);
  localparam int unsigned WB_W       = $clog2(BE_W);
  localparam int unsigned RAM_AW     = IDX_W + BEAT_W;

  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[OFF_W + IDX_W +: TAG_W];
  endfunction
  function automatic logic [BEAT_W-1:0] f_beat(input logic [ADDR_W-1:0] a);
    return a[BB_W +: BEAT_W];
  endfunction
  function automatic logic [LANE_W-1:0] f_lane(input logic [ADDR_W-1:0] a);
    return a[WB_W +: LANE_W];
  endfunction
  function automatic logic [RAM_AW-1:0] f_ram_addr(input logic [IDX_W-1:0] i,
                                                   input logic [BEAT_W-1:0] b);
    return {i, b};
  endfunction
  function automatic logic [BEAT_BYTES-1:0] f_lane_mask(input logic [BE_W-1:0] be,
                                                        input logic [LANE_W-1:0] lane);
    return BEAT_BYTES'(be) << (int'(lane) * BE_W);
  endfunction

  wbc_state_e            state;
  logic [BEAT_W-1:0]     beat;
  logic                  way_q, access_go, miss_start, fill_beat, fill_last;
  logic                  hit, hit_way, lru_way, sel_way, sel_dirty;
  logic [TAG_W-1:0]      sel_tag;
  logic [IDX_W-1:0]      cpu_idx;
  logic [TAG_W-1:0]      cpu_tag;
  logic [BEAT_W-1:0]     cpu_beat;
  logic [LANE_W-1:0]     cpu_lane;
  logic [1:0][MEM_W-1:0] rd_line;
  logic [RAM_AW-1:0]     rd_addr, wr_addr;
  logic                  wr_en, wr_way, touch, touch_way, mark_dirty;
  logic [MEM_W-1:0]      wr_data;
  logic [BEAT_BYTES-1:0] wr_mask;

  assign cpu_idx  = f_index(cpu_addr);
  assign cpu_tag  = f_tag(cpu_addr);
  assign cpu_beat = f_beat(cpu_addr);
  assign cpu_lane = f_lane(cpu_addr);

  assign sel_way    = (state == ST_LOOKUP) ? lru_way : way_q;
  assign touch      = access_go || fill_last;
  assign touch_way  = fill_last ? way_q : hit_way;
  assign mark_dirty = access_go && cpu_we;

  wbc_tags #(.SETS(SETS), .TAG_W(TAG_W), .PRESET(PRESET)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(cpu_idx), .lk_tag(cpu_tag), .sel_way(sel_way),
    .touch(touch), .touch_way(touch_way), .mark_dirty(mark_dirty),
    .fill(fill_last), .fill_way(way_q), .fill_tag(cpu_tag),
    .hit(hit), .hit_way(hit_way), .lru_way(lru_way),
    .sel_tag(sel_tag), .sel_dirty(sel_dirty)
  );

  wbc_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req),
    .hit(hit), .hit_way(hit_way), .lru_way(lru_way), .sel_dirty(sel_dirty),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .state(state), .beat(beat), .way_q(way_q),
    .access_go(access_go), .miss_start(miss_start),
    .mem_req(mem_req), .mem_we(mem_we),
    .fill_beat(fill_beat), .fill_last(fill_last)
  );

  assign rd_addr = f_ram_addr(cpu_idx, (state == ST_WBACK) ? beat : cpu_beat);
  assign wr_en   = (access_go && cpu_we) || fill_beat;
  assign wr_way  = fill_beat ? way_q : hit_way;
  assign wr_addr = f_ram_addr(cpu_idx, fill_beat ? beat : cpu_beat);
  assign wr_data = fill_beat ? mem_rdata : {LANES{cpu_wdata}};
  assign wr_mask = fill_beat ? '1 : f_lane_mask(cpu_be, cpu_lane);

  wbc_data #(.SETS(SETS), .BEATS(BEATS), .MEM_W(MEM_W)) u_data (
    .clk(clk), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_way(wr_way), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_line(rd_line)
  );

  assign cpu_ready = access_go;
  assign cpu_rdata = rd_line[hit_way][int'(cpu_lane) * CPU_W +: CPU_W];
  assign mem_addr  = (state == ST_WBACK) ? {sel_tag, cpu_idx} : {cpu_tag, cpu_idx};
  assign mem_wdata = rd_line[way_q];

  // R2: requests are word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[WB_W-1:0] == '0))
    else $error("a_r2_aligned");

  // R4: completion only answers a live request
  a_r4_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req)
    else $error("a_r4_ready_needs_req");

  // R4: no completion while a line is moving
  a_r4_quiet_during_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid || mem_req) |-> !cpu_ready)
    else $error("a_r4_quiet_during_refill");

  // R9: a pending memory request is held unchanged
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && (!mem_we || $stable(mem_wdata))))
    else $error("a_r9_mem_hold");

  // R5: a miss that starts write-back leaves the set index on the port
  a_r5_victim_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[IDX_W-1:0] == cpu_idx))
    else $error("a_r5_victim_set");
endmodule

// File: tb/tb_twoway_wb_cache.sv
module tb_twoway_wb_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [22:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [14:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #4 clk = ~clk;

  twoway_wb_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0;
  int wb_beats = 0, rd_reqs = 0, hs_viol = 0;
  int last_wb_line = -1, last_rd_line = -1;
  bit finished = 0;

  logic [127:0] mem_beats [int];
  logic [31:0]  ref_w [int];

  typedef struct {
    int          addr;
    bit          we;
    bit          chk;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  function automatic logic [31:0] patword(int w);
    return (w * 32'h9E3779B1) ^ 32'hA5A50000;
  endfunction

  function automatic logic [127:0] beat_val(int b);
    if (mem_beats.exists(b)) return mem_beats[b];
    return {patword(4*b+3), patword(4*b+2), patword(4*b+1), patword(4*b)};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: drive just after the rising edge, sample at the falling edge
  int   tick = 0;
  bit   rd_busy = 0;
  int   rd_line = 0, rd_beat = 0, wb_cnt = 0;
  bit   prev_hold = 0;
  logic prev_we;
  logic [14:0]  prev_addr;
  logic [127:0] prev_wdata;

  always @(posedge clk) begin
    #1;
    tick++;
    mem_ready = (tick % 4) != 3;
    if (rd_busy && (tick % 5) != 2) begin
      mem_rvalid = 1'b1;
      mem_rdata  = beat_val(rd_line * 16 + rd_beat);
    end else begin
      mem_rvalid = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold && !(mem_req && mem_we == prev_we && mem_addr == prev_addr &&
                         (!mem_we || mem_wdata == prev_wdata)))
        hs_viol++;
      prev_hold  = mem_req && !mem_ready;
      prev_we    = mem_we;
      prev_addr  = mem_addr;
      prev_wdata = mem_wdata;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          if (wb_cnt == 0) last_wb_line = int'(mem_addr);
          else if (int'(mem_addr) != last_wb_line) hs_viol++;
          mem_beats[last_wb_line * 16 + wb_cnt] = mem_wdata;
          wb_cnt = (wb_cnt + 1) % 16;
          wb_beats++;
        end else begin
          if (rd_busy || wb_cnt != 0) hs_viol++;
          rd_busy = 1;
          rd_line = int'(mem_addr);
          rd_beat = 0;
          last_rd_line = rd_line;
          rd_reqs++;
        end
      end
      if (mem_rvalid) begin
        rd_beat++;
        if (rd_beat == 16) rd_busy = 0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_req && cpu_ready) begin
      if (sbq.size() == 0) begin
        chk(0, "R4", "completion without pending access", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(int'(cpu_addr) == it.addr, it.tag, "completed address", cpu_addr, it.addr);
        if (!it.we && it.chk)
          chk(cpu_rdata === it.exp, it.tag, $sformatf("read data @%0h", it.addr),
              cpu_rdata, it.exp);
      end
    end
  end

  // driver: pushes the expected item, then holds the request until completion
  task automatic access(bit we, int addr, logic [31:0] wd, logic [3:0] be,
                        string tag, output int lat);
    item_t it;
    int w = addr >> 2;
    it.addr = addr; it.we = we; it.tag = tag; it.chk = 0; it.exp = '0;
    if (we) begin
      if (ref_w.exists(w))         ref_w[w] = merge(ref_w[w], wd, be);
      else if (addr >= 131072)     ref_w[w] = merge(patword(w), wd, be);
      else if (be == 4'hF)         ref_w[w] = wd;
    end else begin
      if (ref_w.exists(w))      begin it.chk = 1; it.exp = ref_w[w]; end
      else if (addr >= 131072)  begin it.chk = 1; it.exp = patword(w); end
    end
    sbq.push_back(it);
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = 23'(addr); cpu_wdata = wd; cpu_be = be;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ready);
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  int lat, wb0, rd0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0, "R1", "ready in reset", cpu_ready, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", {cpu_ready, mem_req}, 0);

    // R1/R2/R3: preset region hits without traffic
    wb0 = wb_beats; rd0 = rd_reqs;
    access(1, 'h00100, 32'h11223344, 4'hF, "R1", lat);
    chk(lat == 1, "R1", "write hit latency", lat, 1);
    access(1, 'h1FFFC, 32'hCAFEF00D, 4'hF, "R1", lat);
    chk(lat == 1, "R1", "top word hit latency", lat, 1);
    access(0, 'h00100, '0, '0, "R2", lat);
    chk(lat == 1, "R2", "read hit latency", lat, 1);
    access(0, 'h1FFFC, '0, '0, "R2", lat);
    access(1, 'h00100, 32'hAABBCCDD, 4'b0101, "R3", lat);
    access(0, 'h00100, '0, '0, "R3", lat);
    chk(ref_w['h40] == 32'h11BB33DD, "R3", "merged reference", ref_w['h40], 32'h11BB33DD);
    chk(wb_beats == wb0 && rd_reqs == rd0, "R3", "no memory traffic on hits",
        wb_beats - wb0 + rd_reqs - rd0, 0);

    // R6/R7: clean victim (way 0 of set 0), refill of line 0x200
    wb0 = wb_beats; rd0 = rd_reqs;
    access(0, 'h20000, '0, '0, "R7", lat);
    chk(lat > 17, "R4", "miss stall length", lat, 18);
    chk(wb_beats == wb0, "R6", "write beats for clean victim", wb_beats - wb0, 0);
    chk(rd_reqs == rd0 + 1, "R7", "read requests", rd_reqs - rd0, 1);
    chk(last_rd_line == 'h200, "R7", "refill line address", last_rd_line, 'h200);
    access(0, 'h200F0, '0, '0, "R7", lat);
    chk(lat == 1, "R7", "last beat resident", lat, 1);
    access(0, 'h20074, '0, '0, "R7", lat);

    // R8: LRU choice in set 0
    access(0, 'h10000, '0, '0, "R8", lat);
    chk(lat == 1, "R8", "way 1 preset hit", lat, 1);
    access(0, 'h30000, '0, '0, "R8", lat);
    chk(lat > 1, "R8", "miss on new tag", lat, 18);
    access(0, 'h10004, '0, '0, "R8", lat);
    chk(lat == 1, "R8", "recently used way kept", lat, 1);
    access(0, 'h20000, '0, '0, "R8", lat);
    chk(lat > 1, "R8", "LRU way was evicted", lat, 18);

    // R5: dirty victim in set 1 (line 0x001)
    access(0, 'h10100, '0, '0, "R8", lat);
    wb0 = wb_beats; rd0 = rd_reqs;
    access(0, 'h40100, '0, '0, "R5", lat);
    chk(wb_beats == wb0 + 16, "R5", "write-back beat count", wb_beats - wb0, 16);
    chk(last_wb_line == 'h001, "R5", "write-back line address", last_wb_line, 'h001);
    chk(mem_beats.exists(16) && mem_beats[16][31:0] == 32'h11BB33DD, "R5",
        "beat 0 lane 0 of written line", mem_beats[16][31:0], 32'h11BB33DD);
    wb0 = wb_beats;
    access(0, 'h00100, '0, '0, "R5", lat);
    chk(lat > 1, "R5", "evicted line refetched", lat, 18);
    chk(wb_beats == wb0, "R6", "clean preset victim not written", wb_beats - wb0, 0);

    // R4: write miss allocates then merges
    access(1, 'h50204, 32'h0BADBEEF, 4'b1100, "R4", lat);
    chk(lat > 1, "R4", "write miss stalls", lat, 18);
    access(0, 'h50204, '0, '0, "R4", lat);
    chk(lat == 1, "R4", "allocated line hits", lat, 1);

    // R7/R8 mixed traffic across sets 2..5 and several tags
    for (int k = 0; k < 48; k++) begin
      int a = ((2 + k % 5) << 16) | ((2 + (k * 3) % 4) << 8) | (((k * 7) % 64) << 2);
      if (k % 3 == 0) access(1, a, 32'h1000_0000 + k, (k % 2) ? 4'hF : 4'b0011, "R7", lat);
      else            access(0, a, '0, '0, "R7", lat);
    end
    for (int k = 0; k < 48; k += 3) begin
      int a = ((2 + k % 5) << 16) | ((2 + (k * 3) % 4) << 8) | (((k * 7) % 64) << 2);
      access(0, a, '0, '0, "R5", lat);
    end

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R4", "all accesses completed", sbq.size(), 0);
    chk(hs_viol == 0, "R9", "memory handshake violations", hs_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule